// File: doc/BRIEF.md
# Receive Descriptor Fill Controller

This block moves received frames from a receive FIFO into empty buffers that software has set aside in a ring of receive descriptors. Each descriptor is two 32-bit words: a control word carrying an empty flag, a wrap flag, a last flag, eight frame status bits and a byte length, followed by a pointer to the buffer. Every buffer has the same size, taken from a single configuration input, because the length of an incoming frame is not known before it arrives.

The FIFO delivers a frame's data words and then one status word. That word carries the frame's byte length and its eight status bits. The controller fetches a descriptor, stores data words one after another into its buffer and moves on to the next descriptor when the buffer is full. When it closes a buffer, it rewrites the control word in a single write. For the final buffer it also writes the frame status and then raises a one-cycle completion pulse. If no empty descriptor is available, the data is discarded.

Top module: `rxd_fill_ctrl`

## Requirements
- R1: Data words are written to consecutive word addresses from the buffer pointer upward. A buffer holds at most `cfg_buf_size` bytes, a multiple of 4.
- R2: A descriptor at ring index i has its control word at `cfg_ring_base + 8*i` and its pointer at the next word. Only descriptors whose empty flag (control bit 31) is 1 receive data, and they are used in ring order.
- R3: Closing a buffer is one write of the control word. That write puts 0 in the empty flag, writes the length (bits 15:0) and the last flag (bit 27), and keeps the wrap flag (bit 29) as it was read.
- R4: Every buffer of a frame except the final one is closed with last = 0, status bits 0 and length = `cfg_buf_size`.
- R5: The final buffer of a frame is closed with last = 1. Its status bits 23:16 are copied from the status word, and its length is the frame length minus the bytes already stored in earlier buffers of the frame.
- R6: A FIFO word flagged by `fifo_stat` is the status word: bits 15:0 hold the frame byte length and bits 23:16 the status bits. The block pops a FIFO word only while `fifo_valid` is high.
- R7: After a descriptor whose wrap flag is 1, the next descriptor used is index 0.
- R8: If a frame needs a further buffer but the next descriptor is not empty, the rest of the frame's data is dropped and that descriptor is not written. The current buffer is closed as the final one, with the overrun status bit (control bit 17) set and its length equal to the bytes it holds.
- R9: If no empty descriptor is available when a frame starts, the whole frame is dropped, nothing is written and no pulse is raised. The same descriptor is tried again for the next frame.
- R10: A frame that exactly fills its buffer occupies only that descriptor; the next descriptor is not written.
- R11: `frame_done` is high for one cycle, in the cycle after memory accepts the final control word of a frame.
- R12: A memory request holds its address, direction and write data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | AW | Byte address of descriptor 0 |
| cfg_buf_size | input | LENW | Bytes per receive buffer, multiple of 4 |
| fifo_valid | input | 1 | FIFO head word present |
| fifo_stat | input | 1 | FIFO head word is a frame status word |
| fifo_data | input | 32 | FIFO head word |
| fifo_ready | output | 1 | Pop the FIFO head word this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| frame_done | output | 1 | One-cycle pulse after a frame's final descriptor write |

## Verification
The bench builds the block with a 16-bit address, a 3-bit ring index and 16-byte buffers, and uses a ring of three descriptors whose third carries the wrap flag. With four words per buffer, a nine-word frame crosses two buffer boundaries and the wrap point, and an exact-fit frame, an overrun and a frame dropped for lack of a buffer each take only a few words. Because index 3 also fits in the ring index, skipping the wrap flag would show up as a write to a fourth slot. A toggling acknowledge exercises memory stalls.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int CTL_EMPTY_BIT = 31;
    localparam int CTL_WRAP_BIT  = 29;
    localparam int CTL_LAST_BIT  = 27;
    localparam int CTL_STAT_LO   = 16;
    localparam int STAT_OVR_BIT  = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_CTL,
        S_RD_PTR,
        S_RD_NXT,
        S_WR_DATA,
        S_WR_CLOSE,
        S_WR_LAST
    } fill_st_e;
endpackage

// File: rtl/rxd_ring_addr.sv
module rxd_ring_addr #(
    parameter int AW   = 32,
    parameter int IDXW = 4
) (
    input  logic [AW-1:0]   base,
    input  logic [IDXW-1:0] idx,
    input  logic            wrap,
    output logic [AW-1:0]   ctl_addr,
    output logic [AW-1:0]   ptr_addr,
    output logic [IDXW-1:0] nxt_idx,
    output logic [AW-1:0]   nxt_ctl_addr
);
    localparam int SLOT_SHIFT = 3;

    always_comb begin
        nxt_idx      = wrap ? '0 : idx + 1'b1;
        ctl_addr     = base + AW'({idx, {SLOT_SHIFT{1'b0}}});
        ptr_addr     = ctl_addr + AW'(4);
        nxt_ctl_addr = base + AW'({nxt_idx, {SLOT_SHIFT{1'b0}}});
    end
endmodule

// File: rtl/rxd_ctl_pack.sv
module rxd_ctl_pack #(
    parameter int LENW = 16
) (
    input  logic            last,
    input  logic            wrap,
    input  logic [7:0]      stat,
    input  logic [LENW-1:0] len,
    output logic [31:0]     word
);
    import rxd_pkg::*;

    always_comb begin
        word                              = '0;
        word[LENW-1:0]                    = len;
        word[CTL_STAT_LO+7:CTL_STAT_LO]   = stat;
        word[CTL_LAST_BIT]                = last;
        word[CTL_WRAP_BIT]                = wrap;
        word[CTL_EMPTY_BIT]               = 1'b0;
    end
endmodule

// File: rtl/rxd_len_calc.sv
module rxd_len_calc #(
    parameter int LENW = 16
) (
    input  logic [LENW-1:0] frame_len,
    input  logic [LENW-1:0] prior,
    input  logic [LENW-1:0] held,
    input  logic            ovr,
    output logic [LENW-1:0] last_len
);
    always_comb begin
        if (ovr) last_len = held;
        else     last_len = frame_len - prior;
    end
endmodule

// File: rtl/rxd_fill_ctrl.sv
module rxd_fill_ctrl #(
    parameter int AW   = 32,
    parameter int IDXW = 4,
    parameter int LENW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   cfg_ring_base,
    input  logic [LENW-1:0] cfg_buf_size,
    input  logic            fifo_valid,
    input  logic            fifo_stat,
    input  logic [31:0]     fifo_data,
    output logic            fifo_ready,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            frame_done
);
    import rxd_pkg::*;

    localparam int WORD_BYTES = 4;

    typedef struct packed {
        fill_st_e        st;
        logic [IDXW-1:0] idx;
        logic            wrap;
        logic            nwrap;
        logic [AW-1:0]   ptr;
        logic [LENW-1:0] off;
        logic [LENW-1:0] prior;
        logic            open;
        logic            drop;
        logic            ovr;
        logic [31:0]     word;
        logic            done;
    } fill_t;

    fill_t q, d;

    logic [AW-1:0]   ctl_addr, ptr_addr, nxt_ctl_addr;
    logic [IDXW-1:0] nxt_idx;
    logic [LENW-1:0] last_len, pack_len;
    logic [7:0]      pack_stat;
    logic            pack_last;
    logic [31:0]     ctl_word;
    fill_st_e        st_now;

    assign st_now = q.st;

    rxd_ring_addr #(.AW(AW), .IDXW(IDXW)) u_ring (
        .base         (cfg_ring_base),
        .idx          (q.idx),
        .wrap         (q.wrap),
        .ctl_addr     (ctl_addr),
        .ptr_addr     (ptr_addr),
        .nxt_idx      (nxt_idx),
        .nxt_ctl_addr (nxt_ctl_addr)
    );

    rxd_len_calc #(.LENW(LENW)) u_len (
        .frame_len (q.word[LENW-1:0]),
        .prior     (q.prior),
        .held      (q.off),
        .ovr       (q.ovr),
        .last_len  (last_len)
    );

    always_comb begin
        pack_last = (q.st == S_WR_LAST);
        pack_len  = pack_last ? last_len : cfg_buf_size;
        pack_stat = '0;
        if (pack_last) begin
            pack_stat = q.word[CTL_STAT_LO+7:CTL_STAT_LO];
            pack_stat[STAT_OVR_BIT] = pack_stat[STAT_OVR_BIT] | q.ovr;
        end
    end

    rxd_ctl_pack #(.LENW(LENW)) u_pack (
        .last (pack_last),
        .wrap (q.wrap),
        .stat (pack_stat),
        .len  (pack_len),
        .word (ctl_word)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        fifo_ready = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        unique case (q.st)
            S_IDLE: begin
                if (fifo_valid) begin
                    if (fifo_stat) begin
                        fifo_ready = 1'b1;
                        if (q.open) begin
                            d.word = fifo_data;
                            d.st   = S_WR_LAST;
                        end else begin
                            d.drop  = 1'b0;
                            d.ovr   = 1'b0;
                            d.prior = '0;
                        end
                    end else if (q.drop) begin
                        fifo_ready = 1'b1;
                    end else if (!q.open) begin
                        d.st = S_RD_CTL;
                    end else if (q.off >= cfg_buf_size) begin
                        d.st = S_RD_NXT;
                    end else begin
                        fifo_ready = 1'b1;
                        d.word     = fifo_data;
                        d.st       = S_WR_DATA;
                    end
                end
            end
            S_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = ctl_addr;
                if (mem_ack) begin
                    d.word = mem_rdata;
                    if (mem_rdata[CTL_EMPTY_BIT]) begin
                        d.wrap = mem_rdata[CTL_WRAP_BIT];
                        d.st   = S_RD_PTR;
                    end else begin
                        d.drop = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ptr_addr;
                if (mem_ack) begin
                    d.ptr  = mem_rdata[AW-1:0];
                    d.open = 1'b1;
                    d.off  = '0;
                    d.st   = S_IDLE;
                end
            end
            S_RD_NXT: begin
                mem_req  = 1'b1;
                mem_addr = nxt_ctl_addr;
                if (mem_ack) begin
                    d.word = mem_rdata;
                    if (mem_rdata[CTL_EMPTY_BIT]) begin
                        d.nwrap = mem_rdata[CTL_WRAP_BIT];
                        d.st    = S_WR_CLOSE;
                    end else begin
                        d.ovr  = 1'b1;
                        d.drop = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ptr + AW'(q.off);
                mem_wdata = q.word;
                if (mem_ack) begin
                    d.off = q.off + LENW'(WORD_BYTES);
                    d.st  = S_IDLE;
                end
            end
            S_WR_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctl_addr;
                mem_wdata = ctl_word;
                if (mem_ack) begin
                    d.prior = q.prior + cfg_buf_size;
                    d.idx   = nxt_idx;
                    d.wrap  = q.nwrap;
                    d.open  = 1'b0;
                    d.st    = S_RD_PTR;
                end
            end
            S_WR_LAST: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctl_addr;
                mem_wdata = ctl_word;
                if (mem_ack) begin
                    d.idx   = nxt_idx;
                    d.open  = 1'b0;
                    d.drop  = 1'b0;
                    d.ovr   = 1'b0;
                    d.prior = '0;
                    d.done  = 1'b1;
                    d.st    = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, idx: '0, wrap: 1'b0, nwrap: 1'b0, ptr: '0,
                   off: '0, prior: '0, open: 1'b0, drop: 1'b0, ovr: 1'b0,
                   word: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign frame_done = q.done;
endmodule

// File: rtl/rxd_fill_chk.sv
module rxd_fill_chk #(
    parameter int AW   = 32,
    parameter int LENW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LENW-1:0]   cfg_buf_size,
    input logic              fifo_valid,
    input logic              fifo_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              frame_done,
    input rxd_pkg::fill_st_e st
);
    import rxd_pkg::*;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12

    AST_CLOSE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (st == S_WR_CLOSE || st == S_WR_LAST) |-> mem_we && !mem_wdata[CTL_EMPTY_BIT]); // R3

    AST_NONLAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && st == S_WR_CLOSE |-> !mem_wdata[CTL_LAST_BIT] && mem_wdata[LENW-1:0] == cfg_buf_size); // R4

    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(mem_req && mem_ack && mem_we && mem_wdata[CTL_LAST_BIT])); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R11

    AST_POP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ready |-> fifo_valid); // R6
endmodule

bind rxd_fill_ctrl rxd_fill_chk #(.AW(AW), .LENW(LENW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_buf_size (cfg_buf_size),
    .fifo_valid   (fifo_valid),
    .fifo_ready   (fifo_ready),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .frame_done   (frame_done),
    .st           (st_now)
);

// File: tb/rxd_fill_ctrl_bench.sv
module rxd_fill_ctrl_bench;
    localparam int AW   = 16;
    localparam int IDXW = 3;
    localparam int LENW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0]   cfg_ring_base = '0;
    logic [LENW-1:0] cfg_buf_size  = 16'd16;
    logic            fifo_valid, fifo_stat, fifo_ready;
    logic [31:0]     fifo_data;
    logic            mem_req, mem_we, mem_ack, frame_done;
    logic [AW-1:0]   mem_addr;
    logic [31:0]     mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [0:255];
    logic        slow = 1'b0;
    logic        lat_q = 1'b0;
    logic        bw_en = 1'b0;
    logic [AW-1:0] bw_addr = '0;
    logic [31:0] bw_data = '0;

    logic [31:0] q_data [0:63];
    logic        q_stat [0:63];
    int qw = 0;
    int qr = 0;

    int done_cnt = 0;
    int hold_viol = 0;
    int pulse_viol = 0;
    logic last_wr_q = 1'b0;
    logic done_d = 1'b0;
    logic pend_q = 1'b0;
    logic [AW-1:0] pend_addr = '0;

    assign fifo_valid = (qr < qw);
    assign fifo_data  = fifo_valid ? q_data[qr[5:0]] : '0;
    assign fifo_stat  = fifo_valid ? q_stat[qr[5:0]] : 1'b0;
    assign mem_rdata  = mem[mem_addr[9:2]];
    assign mem_ack    = mem_req && (!slow || lat_q);

    rxd_fill_ctrl #(.AW(AW), .IDXW(IDXW), .LENW(LENW)) u_rxd_fill_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cfg_ring_base (cfg_ring_base), .cfg_buf_size (cfg_buf_size),
        .fifo_valid (fifo_valid), .fifo_stat (fifo_stat), .fifo_data (fifo_data),
        .fifo_ready (fifo_ready),
        .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
        .frame_done (frame_done)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            lat_q <= 1'b0;
        end else begin
            lat_q <= slow ? !lat_q : 1'b0;
            if (bw_en) mem[bw_addr[9:2]] <= bw_data;
            else if (mem_req && mem_ack && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
        if (fifo_valid && fifo_ready) qr <= qr + 1;
        if (rst_n) begin
            if (frame_done) done_cnt <= done_cnt + 1;
            if (frame_done && (done_d || !last_wr_q)) pulse_viol <= pulse_viol + 1;
            if (pend_q && (!mem_req || mem_addr != pend_addr)) hold_viol <= hold_viol + 1;
        end
        done_d    <= frame_done;
        last_wr_q <= mem_req && mem_ack && mem_we && mem_wdata[27];
        pend_q    <= mem_req && !mem_ack;
        pend_addr <= mem_addr;
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic logic [31:0] ctlw(input bit last, input bit wrap,
                                         input logic [7:0] st, input logic [15:0] len);
        return (32'(wrap) << 29) | (32'(last) << 27) | (32'(st) << 16) | 32'(len);
    endfunction

    function automatic logic [31:0] dw(input int id, input int k);
        return {8'(id), 24'(k)};
    endfunction

    task automatic mw(input int addr, input logic [31:0] data);
        @(negedge clk);
        bw_en = 1'b1; bw_addr = AW'(addr); bw_data = data;
        @(negedge clk);
        bw_en = 1'b0;
    endtask

    task automatic arm(input int i);
        mw(i * 8, 32'h8000_0000 | ((i == 2) ? 32'h2000_0000 : 32'h0));
        mw(i * 8 + 4, 32'h100 + i * 32'h40);
    endtask

    task automatic send(input int id, input int nw, input int len, input logic [7:0] st);
        for (int k = 0; k < nw; k++) begin
            q_data[qw[5:0]] = dw(id, k); q_stat[qw[5:0]] = 1'b0; qw++;
        end
        q_data[qw[5:0]] = {8'h0, st, 16'(len)}; q_stat[qw[5:0]] = 1'b1; qw++;
        wait (qr == qw);
        repeat (30) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R11 reset frame_done", 32'(frame_done), 32'h0);
        chk("R12 reset mem_req", 32'(mem_req), 32'h0);
        chk("R6 reset fifo_ready", 32'(fifo_ready), 32'h0);
    endtask

    task automatic t_single;
        send(1, 3, 10, 8'h40);
        for (int k = 0; k < 3; k++) chk("R1 data in buffer 0", mem[(32'h100 >> 2) + k], dw(1, k));
        chk("R5 single close", mem[0], ctlw(1, 0, 8'h40, 10));
        chk("R11 pulse count", 32'(done_cnt), 32'd1);
    endtask

    task automatic t_multi;
        arm(0);
        send(2, 9, 34, 8'h20);
        for (int k = 0; k < 4; k++) chk("R1 first buffer", mem[(32'h140 >> 2) + k], dw(2, k));
        for (int k = 0; k < 4; k++) chk("R2 second buffer", mem[(32'h180 >> 2) + k], dw(2, 4 + k));
        chk("R4 non-last close idx1", mem[2], ctlw(0, 0, 8'h00, 16));
        chk("R3 wrap kept in close idx2", mem[4], ctlw(0, 1, 8'h00, 16));
        chk("R7 wrap returns to idx0 data", mem[32'h100 >> 2], dw(2, 8));
        chk("R5 final length remainder", mem[0], ctlw(1, 0, 8'h20, 2));
        chk("R7 slot 3 untouched", mem[6], 32'h0);
        chk("R11 pulse count", 32'(done_cnt), 32'd2);
    endtask

    task automatic t_overrun;
        arm(1);
        send(3, 6, 24, 8'h00);
        for (int k = 0; k < 4; k++) chk("R8 data before overrun", mem[(32'h140 >> 2) + k], dw(3, k));
        chk("R8 overrun close", mem[2], ctlw(1, 0, 8'h02, 16));
        chk("R8 busy desc unchanged", mem[4], ctlw(0, 1, 8'h00, 16));
        chk("R8 busy buffer unchanged", mem[32'h180 >> 2], dw(2, 4));
        chk("R11 pulse count", 32'(done_cnt), 32'd3);
    endtask

    task automatic t_nobuf;
        send(4, 2, 7, 8'h00);
        chk("R9 desc unchanged", mem[4], ctlw(0, 1, 8'h00, 16));
        chk("R9 buffer unchanged", mem[32'h180 >> 2], dw(2, 4));
        chk("R9 no pulse", 32'(done_cnt), 32'd3);
        arm(2);
        send(5, 2, 5, 8'h81);
        chk("R9 retry same desc data", mem[32'h180 >> 2], dw(5, 0));
        chk("R2 retry data word 1", mem[(32'h180 >> 2) + 1], dw(5, 1));
        chk("R5 retry close", mem[4], ctlw(1, 1, 8'h81, 5));
        chk("R11 pulse count", 32'(done_cnt), 32'd4);
    endtask

    task automatic t_exact;
        arm(0);
        arm(1);
        slow = 1'b1;
        send(6, 4, 16, 8'h00);
        slow = 1'b0;
        for (int k = 0; k < 4; k++) chk("R12 stalled data", mem[(32'h100 >> 2) + k], dw(6, k));
        chk("R10 exact-fit close", mem[0], ctlw(1, 0, 8'h00, 16));
        chk("R10 next desc untouched", mem[2], 32'h8000_0000);
        chk("R11 pulse count", 32'(done_cnt), 32'd5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        arm(0); arm(1); arm(2);
        t_single();
        t_multi();
        t_overrun();
        t_nobuf();
        t_exact();
        chk("R12 request held until ack", 32'(hold_viol), 32'h0);
        chk("R11 single-cycle pulse after final write", 32'(pulse_viol), 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule